// File: doc/BRIEF.md
# Byte Register Bank with 16-bit Pair Operations

This block holds the working registers of an 8-bit processor. It has six general byte registers, an accumulator and a 16-bit stack pointer. Each cycle it takes at most one decoded instruction byte, together with up to two immediate data bytes. It then executes the register-side part of that instruction: byte moves, immediate loads, byte increment and decrement, pair loads, pair increment and decrement, a 16-bit add into the HL pair, the HL/DE swap and the stack-pointer load from HL.

A 3-bit register field can name the memory byte instead of a register. The block never reaches memory itself. It raises a read or a write strobe, presents the address formed from H (high byte) and L (low byte), takes the read byte on `mem_rdata` and drives the write byte on `mem_wdata`, all within the instruction's own cycle. Flag results are produced combinationally with write strobes for an external status register. Byte increment and decrement report zero, sign, parity and half-carry. The 16-bit add reports only carry. A readback port makes any register visible.

Top module: `regbank8`

## Requirements
- R1: After reset every register (codes 000-101 and 111) reads zero and the stack pointer is zero.
- R2: Register codes are B=000, C=001, D=010, E=011, H=100, L=101, A=111. Opcode 01 ddd sss copies register sss into register ddd, and `rd_sel` reads back the register with that code.
- R3: Code 110 names the memory byte at address {H,L} (`mem_addr`). As a source it raises `mem_rd` and uses `mem_rdata`. As a destination it raises `mem_wr` with the byte on `mem_wdata` and changes no register. A read-modify op on 110 raises both strobes.
- R4: Opcode 0x76 is not a move: it pulses `halt_o` and changes no register.
- R5: Opcode 00 rrr 110 loads `imm_lo` into register rrr.
- R6: Opcodes 00 rrr 100 (increment) and 00 rrr 101 (decrement) change the byte by one modulo 256. Each raises `flag_we_szpa` with: zero = result is 0; sign = result bit 7; parity = 1 for an even count of ones; half-carry = operand low nibble was 0xF on increment, or was not 0x0 on decrement. `flag_we_cy` stays low.
- R7: Opcode 00 pp0 001 loads {`imm_hi`,`imm_lo`} into pair pp (00 BC, 01 DE, 10 HL, 11 stack pointer). `imm_lo` goes to the low register (C, E, L, SP low).
- R8: Opcodes 00 pp0 011 and 00 pp1 011 increment and decrement pair pp modulo 65536 and raise no flag strobe.
- R9: Opcode 00 pp1 001 sets HL to HL plus pair pp modulo 65536. It raises `flag_we_cy` with `flag_cy` equal to the carry out of bit 15, and leaves `flag_we_szpa` low.
- R10: Opcode 0xEB swaps HL with DE, and opcode 0xF9 copies HL into the stack pointer.
- R11: With `op_valid` low, or with any opcode not listed above, no register changes and no strobe rises.
- R12: Register results become visible on `rd_data`/`sp_o` only after the next rising clock edge. Memory strobes, memory data and flag outputs are valid in the same cycle as the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Instruction byte |
| imm_lo | input | DW | First immediate data byte |
| imm_hi | input | DW | Second immediate data byte |
| mem_rdata | input | DW | Memory byte at `mem_addr` |
| mem_addr | output | 2*DW | Memory address {H,L} |
| mem_rd | output | 1 | Instruction reads the memory byte |
| mem_wr | output | 1 | Instruction writes the memory byte |
| mem_wdata | output | DW | Byte to write to memory |
| flag_we_szpa | output | 1 | Strobe for zero/sign/parity/half-carry |
| flag_we_cy | output | 1 | Strobe for carry |
| flag_z | output | 1 | Zero result |
| flag_s | output | 1 | Sign result |
| flag_p | output | 1 | Even parity result |
| flag_ac | output | 1 | Half-carry result |
| flag_cy | output | 1 | Carry out of the 16-bit add |
| halt_o | output | 1 | Halt opcode seen |
| rd_sel | input | 3 | Readback register code |
| rd_data | output | DW | Readback byte (0 for code 110) |
| sp_o | output | 2*DW | Stack pointer value |

## Verification
Two kinds of result have different due times. Memory strobes, write data and flags are combinational, so they are due in the cycle the instruction is presented. The bench samples them one time unit after driving the falling-edge stimulus, well before the rising edge. Register and stack-pointer results are due one rising edge later. The bench therefore sweeps all readback codes and the stack pointer in the half cycle after that edge. Just before the edge it confirms that the readback still shows the old values, which pins down the one-cycle latency.

// File: rtl/regbank8_pkg.sv
package regbank8_pkg;

  localparam int CODE_MEM = 6;
  localparam int NUM_CODES = 8;

  localparam logic [7:0] OPC_HALT = 8'h76;
  localparam logic [7:0] OPC_SWAP = 8'hEB;
  localparam logic [7:0] OPC_SPLD = 8'hF9;

  typedef enum logic [3:0] {
    K_NONE, K_MOV, K_MVI, K_INR, K_DCR, K_LXI,
    K_INX, K_DCX, K_DAD, K_SWAP, K_SPLD, K_HALT
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] dst;
    logic [2:0] src;
    logic [1:0] pair;
  } dec_t;

endpackage

// File: rtl/regbank8_decode.sv
module regbank8_decode
  import regbank8_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec.kind = K_NONE;
    dec.dst  = opcode[5:3];
    dec.src  = opcode[2:0];
    dec.pair = opcode[5:4];
    if (valid) begin
      case (opcode[7:6])
        2'b01: dec.kind = (opcode == OPC_HALT) ? K_HALT : K_MOV;
        2'b00: begin
          case (opcode[2:0])
            3'b110: dec.kind = K_MVI;
            3'b100: dec.kind = K_INR;
            3'b101: dec.kind = K_DCR;
            3'b001: dec.kind = opcode[3] ? K_DAD : K_LXI;
            3'b011: dec.kind = opcode[3] ? K_DCX : K_INX;
            default: dec.kind = K_NONE;
          endcase
        end
        2'b11: begin
          if (opcode == OPC_SWAP)      dec.kind = K_SWAP;
          else if (opcode == OPC_SPLD) dec.kind = K_SPLD;
          else                         dec.kind = K_NONE;
        end
        default: dec.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/regbank8_step8.sv
module regbank8_step8 #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         down,
  output logic [W-1:0] res,
  output logic         zf,
  output logic         sf,
  output logic         pf,
  output logic         acf
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res = down ? (val - ONE) : (val + ONE);
    zf  = (res == '0);
    sf  = res[W-1];
    pf  = ~^res;
    acf = down ? (val[3:0] != 4'h0) : (val[3:0] == 4'hF);
  end

endmodule

// File: rtl/regbank8_step16.sv
module regbank8_step16
  import regbank8_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] hl,
  input  kind_e        kind,
  output logic [W-1:0] res,
  output logic         cy
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, hl} + {1'b0, opnd};
    cy  = 1'b0;
    case (kind)
      K_INX:   res = opnd + ONE;
      K_DCX:   res = opnd - ONE;
      K_DAD: begin
        res = sum[W-1:0];
        cy  = sum[W];
      end
      default: res = opnd;
    endcase
  end

endmodule

// File: rtl/regbank8.sv
module regbank8
  import regbank8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] imm_lo,
  input  logic [DW-1:0] imm_hi,
  input  logic [DW-1:0] mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          flag_we_szpa,
  output logic          flag_we_cy,
  output logic          flag_z,
  output logic          flag_s,
  output logic          flag_p,
  output logic          flag_ac,
  output logic          flag_cy,
  output logic          halt_o,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [2*DW-1:0] sp_o
);

  localparam int PW = 2 * DW;
  localparam int SNAP_W = 7 * DW + PW;

  dec_t d;
  logic [DW-1:0] rf [NUM_CODES];
  logic [PW-1:0] sp_q;
  logic [PW-1:0] hl, de, pair_opnd, wide_val, step16_res;
  logic [DW-1:0] step8_in, step8_res, byte_val;
  logic          byte_op, dst_is_mem, src_is_mem, step_op;
  logic          wr8_en, wr16_en, swap_en, step16_cy;
  logic [1:0]    wr16_idx;
  logic [SNAP_W-1:0] state_snap;

  regbank8_decode u_dec (.valid(op_valid), .opcode(opcode), .dec(d));

  assign hl = {rf[4], rf[5]};
  assign de = {rf[2], rf[3]};

  always_comb begin
    case (d.pair)
      2'd0:    pair_opnd = {rf[0], rf[1]};
      2'd1:    pair_opnd = de;
      2'd2:    pair_opnd = hl;
      default: pair_opnd = sp_q;
    endcase
  end

  // byte path
  assign dst_is_mem = (d.dst == 3'(CODE_MEM));
  assign src_is_mem = (d.src == 3'(CODE_MEM));
  assign step_op    = (d.kind == K_INR) || (d.kind == K_DCR);
  assign byte_op    = step_op || (d.kind == K_MOV) || (d.kind == K_MVI);
  assign step8_in   = dst_is_mem ? mem_rdata : rf[d.dst];

  regbank8_step8 #(.W(DW)) u_step8 (
    .val(step8_in), .down(d.kind == K_DCR), .res(step8_res),
    .zf(flag_z), .sf(flag_s), .pf(flag_p), .acf(flag_ac)
  );

  always_comb begin
    case (d.kind)
      K_MOV:   byte_val = src_is_mem ? mem_rdata : rf[d.src];
      K_MVI:   byte_val = imm_lo;
      default: byte_val = step8_res;
    endcase
  end

  assign wr8_en    = byte_op && !dst_is_mem;
  assign mem_wr    = byte_op && dst_is_mem;
  assign mem_rd    = ((d.kind == K_MOV) && src_is_mem) || (step_op && dst_is_mem);
  assign mem_wdata = byte_val;
  assign mem_addr  = hl;

  // pair path
  regbank8_step16 #(.W(PW)) u_step16 (
    .opnd(pair_opnd), .hl(hl), .kind(d.kind), .res(step16_res), .cy(step16_cy)
  );

  always_comb begin
    case (d.kind)
      K_LXI:   wide_val = {imm_hi, imm_lo};
      K_SPLD:  wide_val = hl;
      default: wide_val = step16_res;
    endcase
  end

  assign wr16_en  = (d.kind == K_LXI) || (d.kind == K_INX) || (d.kind == K_DCX) ||
                    (d.kind == K_DAD) || (d.kind == K_SPLD);
  assign wr16_idx = (d.kind == K_DAD) ? 2'd2 : (d.kind == K_SPLD) ? 2'd3 : d.pair;
  assign swap_en  = (d.kind == K_SWAP);

  assign flag_we_szpa = step_op;
  assign flag_we_cy   = (d.kind == K_DAD);
  assign flag_cy      = step16_cy;
  assign halt_o       = (d.kind == K_HALT);

  // storage: one byte register per code except the memory code
  for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_reg
    if (gi == CODE_MEM) begin : g_hole
      assign rf[gi] = '0;
    end else begin : g_store
      localparam bit IN_PAIR = (gi < 6);
      localparam bit IN_SWAP = (gi >= 2) && (gi < 6);
      localparam int PIDX    = gi / 2;
      localparam bit IS_LOW  = (gi % 2) == 1;
      localparam int PARTNER = gi ^ 6;
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (wr8_en && (d.dst == 3'(gi)))
          q <= byte_val;
        else if (IN_PAIR && wr16_en && (wr16_idx == 2'(PIDX)))
          q <= IS_LOW ? wide_val[DW-1:0] : wide_val[PW-1:DW];
        else if (IN_SWAP && swap_en)
          q <= rf[PARTNER];
      end
      assign rf[gi] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sp_q <= '0;
    else if (wr16_en && (wr16_idx == 2'd3))
      sp_q <= wide_val;
  end

  assign rd_data    = rf[rd_sel];
  assign sp_o       = sp_q;
  assign state_snap = {rf[0], rf[1], rf[2], rf[3], rf[4], rf[5], rf[7], sp_q};

  // assertions
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> $stable(state_snap)); // R4
  AST_MEMWR_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(state_snap)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(state_snap)); // R11
  AST_PAIR_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (d.kind == K_INX || d.kind == K_DCX) |-> (!flag_we_szpa && !flag_we_cy)); // R8
  AST_HL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (d.kind == K_LXI && d.pair == 2'd2) |=> hl == $past({imm_hi, imm_lo})); // R7
  AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (d.kind == K_LXI && d.pair == 2'd3) |=> sp_q == $past({imm_hi, imm_lo})); // R7
  AST_DAD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (d.kind == K_DAD) |=> hl == PW'($past(hl) + $past(pair_opnd))); // R9
  AST_SWAP_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> (hl == $past(de)) && (de == $past(hl))); // R10
  AST_SP_FROM_HL: assert property (@(posedge clk) disable iff (!rst_n)
    (d.kind == K_SPLD) |=> sp_q == $past(hl)); // R10

endmodule

// File: tb/regbank8_tb_top.sv
module regbank8_tb_top;

  localparam int CLK_PERIOD = 20;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] opcode = '0;
  logic [DW-1:0] imm_lo = '0, imm_hi = '0, mem_rdata = '0;
  logic [2*DW-1:0] mem_addr, sp_o;
  logic mem_rd, mem_wr, flag_we_szpa, flag_we_cy;
  logic flag_z, flag_s, flag_p, flag_ac, flag_cy, halt_o;
  logic [DW-1:0] mem_wdata, rd_data;
  logic [2:0] rd_sel = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int mr[8];
  int msp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regbank8 #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .imm_lo(imm_lo), .imm_hi(imm_hi), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .flag_we_szpa(flag_we_szpa), .flag_we_cy(flag_we_cy),
    .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p), .flag_ac(flag_ac),
    .flag_cy(flag_cy), .halt_o(halt_o), .rd_sel(rd_sel), .rd_data(rd_data),
    .sp_o(sp_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int getp(input int p);
    if (p == 3) return msp;
    return mr[2 * p] * 256 + mr[2 * p + 1];
  endfunction

  function automatic int ones(input int v);
    int n = 0;
    for (int b = 0; b < 8; b++) n += (v >> b) & 1;
    return n;
  endfunction

  task automatic sweep(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i);
      #1;
      chk(req, $sformatf("reg code %0d", i), int'(rd_data), (i == 6) ? 0 : mr[i]);
    end
    chk(req, "stack pointer", int'(sp_o), msp);
  endtask

  task automatic run_op(input bit v, input int op, input int lo, input int hi, input int mrd);
    int e_rd = 0, e_wr = 0, e_wd = 0, e_halt = 0, e_wsz = 0, e_wcy = 0;
    int e_z = 0, e_s = 0, e_p = 0, e_ac = 0, e_cy = 0;
    int pw_en = 0, pw_idx = 0, pw_val = 0;
    int nr[8];
    int nsp;
    int hl;
    string tag = "R11";
    nr = mr;
    nsp = msp;
    hl = getp(2);
    if (v) begin
      int grp = op / 64;
      int mid = (op / 8) % 8;
      int low = op % 8;
      int pp = mid / 2;
      int odd = mid % 2;
      if (op == 118) begin
        tag = "R4"; e_halt = 1;
      end else if (grp == 1) begin
        int val = (low == 6) ? mrd : mr[low];
        tag = (mid == 6 || low == 6) ? "R3" : "R2";
        e_rd = (low == 6);
        if (mid == 6) begin e_wr = 1; e_wd = val; end
        else nr[mid] = val;
      end else if (grp == 0 && low == 6) begin
        tag = (mid == 6) ? "R3" : "R5";
        if (mid == 6) begin e_wr = 1; e_wd = lo; end
        else nr[mid] = lo;
      end else if (grp == 0 && (low == 4 || low == 5)) begin
        int val = (mid == 6) ? mrd : mr[mid];
        int r = (low == 4) ? (val + 1) % 256 : (val + 255) % 256;
        tag = "R6";
        e_wsz = 1;
        e_z = (r == 0); e_s = (r >= 128); e_p = (ones(r) % 2 == 0);
        e_ac = (low == 4) ? (val % 16 == 15) : (val % 16 != 0);
        e_rd = (mid == 6);
        if (mid == 6) begin e_wr = 1; e_wd = r; end
        else nr[mid] = r;
      end else if (grp == 0 && low == 1 && odd == 0) begin
        tag = "R7"; pw_en = 1; pw_idx = pp; pw_val = hi * 256 + lo;
      end else if (grp == 0 && low == 3) begin
        int x = getp(pp);
        tag = "R8"; pw_en = 1; pw_idx = pp;
        pw_val = odd ? (x + 65535) % 65536 : (x + 1) % 65536;
      end else if (grp == 0 && low == 1 && odd == 1) begin
        int s = hl + getp(pp);
        tag = "R9"; e_wcy = 1; e_cy = (s > 65535);
        pw_en = 1; pw_idx = 2; pw_val = s % 65536;
      end else if (op == 235) begin
        tag = "R10";
        nr[2] = mr[4]; nr[3] = mr[5]; nr[4] = mr[2]; nr[5] = mr[3];
      end else if (op == 249) begin
        tag = "R10"; nsp = hl;
      end
    end
    if (pw_en) begin
      if (pw_idx == 3) nsp = pw_val;
      else begin nr[2 * pw_idx] = pw_val / 256; nr[2 * pw_idx + 1] = pw_val % 256; end
    end

    @(negedge clk);
    op_valid = v; opcode = op[7:0]; imm_lo = lo[7:0]; imm_hi = hi[7:0]; mem_rdata = mrd[7:0];
    #1;
    chk(tag, "mem_rd", int'(mem_rd), e_rd);
    chk(tag, "mem_wr", int'(mem_wr), e_wr);
    if (e_wr) chk(tag, "mem_wdata", int'(mem_wdata), e_wd);
    chk(tag, "halt_o", int'(halt_o), e_halt);
    chk(tag, "flag_we_szpa", int'(flag_we_szpa), e_wsz);
    chk(tag, "flag_we_cy", int'(flag_we_cy), e_wcy);
    if (e_wsz) begin
      chk("R6", "zero", int'(flag_z), e_z);
      chk("R6", "sign", int'(flag_s), e_s);
      chk("R6", "parity", int'(flag_p), e_p);
      chk("R6", "half-carry", int'(flag_ac), e_ac);
    end
    if (e_wcy) chk("R9", "carry", int'(flag_cy), e_cy);
    chk("R3", "mem_addr", int'(mem_addr), hl);
    chk("R12", "sp before edge", int'(sp_o), msp);
    chk("R12", "readback before edge", int'(rd_data), (rd_sel == 3'd6) ? 0 : mr[rd_sel]);
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    mr = nr;
    msp = nsp;
    sweep(tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mr[i] = 0;
    msp = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    sweep("R1");

    run_op(1, 8'h01, 8'h34, 8'h12, 0);   // R7 BC
    run_op(1, 8'h11, 8'h78, 8'h56, 0);   // R7 DE
    run_op(1, 8'h21, 8'h00, 8'h20, 0);   // R7 HL
    run_op(1, 8'h31, 8'hFF, 8'hFF, 0);   // R7 SP = FFFF
    run_op(1, 8'h33, 0, 0, 0);           // R8 wrap to 0
    run_op(1, 8'h3B, 0, 0, 0);           // R8 wrap to FFFF
    run_op(1, 8'h3E, 8'hA5, 0, 0);       // R5 A
    run_op(1, 8'h36, 8'h5C, 0, 0);       // R3 store immediate to memory
    run_op(1, 8'h46, 0, 0, 8'h9D);       // R3 B <- memory
    run_op(1, 8'h70, 0, 0, 0);           // R3 memory <- B
    run_op(1, 8'h4F, 0, 0, 0);           // R2 C <- A
    run_op(1, 8'h76, 0, 0, 0);           // R4 halt
    run_op(1, 8'h0E, 8'hFF, 0, 0);       // C = FF
    run_op(1, 8'h0C, 0, 0, 0);           // R6 FF + 1
    run_op(1, 8'h1E, 8'h00, 0, 0);       // E = 0
    run_op(1, 8'h1D, 0, 0, 0);           // R6 00 - 1
    run_op(1, 8'h3E, 8'h0F, 0, 0);
    run_op(1, 8'h3C, 0, 0, 0);           // R6 0F + 1
    run_op(1, 8'h06, 8'h80, 0, 0);
    run_op(1, 8'h05, 0, 0, 0);           // R6 80 - 1
    run_op(1, 8'h34, 0, 0, 8'hFF);       // R3 increment memory
    run_op(1, 8'h11, 8'h00, 8'h80, 0);
    run_op(1, 8'h21, 8'h00, 8'h80, 0);
    run_op(1, 8'h19, 0, 0, 0);           // R9 8000+8000 carry
    run_op(1, 8'h21, 8'h01, 8'h40, 0);
    run_op(1, 8'h29, 0, 0, 0);           // R9 HL doubled
    run_op(1, 8'hEB, 0, 0, 0);           // R10 swap
    run_op(1, 8'hF9, 0, 0, 0);           // R10 SP <- HL
    run_op(0, 8'h06, 8'h11, 0, 0);       // R11 not valid
    run_op(1, 8'h80, 0, 0, 0);           // R11 outside set
    run_op(1, 8'h00, 0, 0, 0);           // R11 outside set

    for (int n = 0; n < 3000; n++) begin
      int op = ($urandom_range(0, 9) < 7) ? $urandom_range(0, 127) : $urandom_range(128, 255);
      run_op(($urandom_range(0, 15) != 0), op, $urandom_range(0, 255),
             $urandom_range(0, 255), $urandom_range(0, 255));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule